// File: doc/BRIEF.md
# Card Power Activation and Fault Controller

This block sequences the supply of a contact card. An active-low power request from the controller starts a soft-start ramp of the card supply. The 5 V / 3 V choice is captured when the request arrives, and the reset, clock and data channels are opened once the supply comparator reports the final level. While the card is powered, fault inputs are watched. A persistent fault, or removal of the card, shuts the supply down and raises an alarm. The alarm stays until the controller withdraws its request.

The analog side is outside the block: the charge pump, the supply comparators (good level, discharged below about 1 V), the output mismatch detectors, the thermal sensor, the controller-supply monitor and the level shifters. Faults pass through a timed filter state before they can raise the alarm, so short glitches are tolerated. Supply underrange and card removal are watched from the moment power is requested. Output mismatch and overtemperature are watched only once the supply is ready. A disabled channel drives its card-side pin low, and its controller-side pin floats.

Top module: `card_pwr_ctrl`

## Requirements
- R1: A high-to-low transition of `pwr_req_ni`, seen while idle with `vcc_low_i` high, raises `pump_en_o` and lowers `discharge_en_o` two clock edges after the first edge that samples the request low.
- R2: `vsel_5v_o` takes the value of `vsel_5v_i` at the request transition. Later changes of `vsel_5v_i` do not alter it until the block has returned to idle and seen a new request.
- R3: `ready_no` goes low one edge after `vcc_good_i` is first sampled high while powered. `rst_chan_en_o` and `clk_chan_en_o` are high exactly when `ready_no` is low.
- R4: `chan_sel_ni` high clears `data_chan_en_o` and leaves the pump, reset and clock outputs unchanged.
- R5: A fault that clears before the filter limit expires causes no alarm, and the ready outputs stay as they were.
- R6: A fault that persists makes `alarm_no` low exactly FAULT_CYCLES+1 edges after the first edge that samples it.
- R7: In alarm, `alarm_no` is 0, `ready_no` is 1, `pump_en_o` is 0 and `discharge_en_o` is 1, and all channel enables are 0. Clearing the fault does not leave alarm. One edge after `pwr_req_ni` is sampled high, the block is idle: pump off, discharge on, `alarm_no` 1, `ready_no` 1.
- R8: A request made while `vcc_low_i` is 0 leaves the block idle. If the request is still held, it is taken one edge after `vcc_low_i` is sampled 1.
- R9: `rst_mismatch_i`, `clk_mismatch_i` and `overtemp_i` have no effect while `ready_no` is high.
- R10: Supply underrange is armed from activation. If `vcc_good_i` is not seen within RAMP_CYCLES of entering the powered state, the underrange fault enters the filter. An underrange present during the ramp ends in alarm RAMP_CYCLES+FAULT_CYCLES+1 edges after the pump turns on.
- R11: `card_present_i` low while powered sets the alarm on the next edge, with no filter.
- R12: `dvcc_uv_i` high while powered forces idle on the next edge, without alarm. A request still held low is not restarted until it is released and asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_req_ni | input | 1 | Power request, active low |
| vsel_5v_i | input | 1 | Supply select: 1 for 5 V, 0 for 3 V |
| vcc_good_i | input | 1 | Card supply has reached its final level |
| vcc_low_i | input | 1 | Card supply has discharged below about 1 V |
| rst_mismatch_i | input | 1 | Reset output differs from its input |
| clk_mismatch_i | input | 1 | Clock output differs from its input |
| overtemp_i | input | 1 | Overtemperature flag |
| dvcc_uv_i | input | 1 | Controller supply below about 1.5 V |
| card_present_i | input | 1 | Card present (raw) |
| chan_sel_ni | input | 1 | Data channel select, active low |
| pump_en_o | output | 1 | Charge pump enable |
| discharge_en_o | output | 1 | Card supply discharge enable |
| ready_no | output | 1 | Supply ready, active low |
| alarm_no | output | 1 | Alarm, active low |
| vsel_5v_o | output | 1 | Captured supply select |
| rst_chan_en_o | output | 1 | Reset channel enable |
| clk_chan_en_o | output | 1 | Clock channel enable |
| data_chan_en_o | output | 1 | Data channel enable |

## Verification
Every output is decoded from registers, except the data enable, which also follows `chan_sel_ni` directly. A change in a sampled input therefore shows one edge later. Activation takes two edges, because the request is first latched as pending. A persistent fault alarms FAULT_CYCLES+1 edges after it is first seen. A missed ramp alarms RAMP_CYCLES+FAULT_CYCLES+1 edges after the pump turns on. The bench drives inputs just after a falling edge and queues each expected output vector with its due cycle counted in rising edges. A monitor compares the outputs at the falling edge of exactly that cycle.

// File: rtl/card_pwr_pkg.sv
package card_pwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ACTIVE   = 2'd1,
    ST_FLT_WAIT = 2'd2,
    ST_ALARM    = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/card_pwr_timer.sv
module card_pwr_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  // cleared whenever idle, saturates at LAST
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/card_pwr_req.sv
module card_pwr_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_req_ni,
  input  logic vsel_5v_i,
  input  logic idle_i,
  input  logic take_i,
  output logic pending_o,
  output logic vsel_5v_o
);
  logic prev_q, pend_q, vsel_q;
  logic fall;

  assign fall = prev_q && !pwr_req_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
      vsel_q <= 1'b0;
    end else begin
      prev_q <= pwr_req_ni;
      if (pwr_req_ni)          pend_q <= 1'b0;
      else if (take_i)         pend_q <= 1'b0;
      else if (fall && idle_i) pend_q <= 1'b1;
      if (fall && idle_i)      vsel_q <= vsel_5v_i;
    end
  end

  assign pending_o = pend_q;
  assign vsel_5v_o = vsel_q;
endmodule

// File: rtl/card_pwr_fsm.sv
module card_pwr_fsm
  import card_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pending_i,
  input  logic       pwr_req_ni,
  input  logic       vcc_good_i,
  input  logic       vcc_low_i,
  input  logic       rst_mismatch_i,
  input  logic       clk_mismatch_i,
  input  logic       overtemp_i,
  input  logic       dvcc_uv_i,
  input  logic       card_present_i,
  input  logic       ramp_done_i,
  input  logic       flt_done_i,
  output pwr_state_e state_o,
  output logic       reached_o,
  output logic       take_o
);
  pwr_state_e state_q, state_d;
  logic reached_q;
  logic early_flt, late_flt, fault, powered_d;

  // underrange armed from activation; output/thermal faults only once ready
  assign early_flt = !vcc_good_i && (reached_q || ramp_done_i);
  assign late_flt  = reached_q && (rst_mismatch_i || clk_mismatch_i || overtemp_i);
  assign fault     = early_flt || late_flt;
  assign take_o    = (state_q == ST_IDLE) && pending_i && vcc_low_i && !dvcc_uv_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (take_o) state_d = ST_ACTIVE;
      ST_ACTIVE:
        if (dvcc_uv_i || pwr_req_ni) state_d = ST_IDLE;
        else if (!card_present_i)    state_d = ST_ALARM;
        else if (fault)              state_d = ST_FLT_WAIT;
      ST_FLT_WAIT:
        if (dvcc_uv_i || pwr_req_ni) state_d = ST_IDLE;
        else if (!card_present_i)    state_d = ST_ALARM;
        else if (!fault)             state_d = ST_ACTIVE;
        else if (flt_done_i)         state_d = ST_ALARM;
      ST_ALARM:
        if (pwr_req_ni) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign powered_d = (state_d == ST_ACTIVE) || (state_d == ST_FLT_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      reached_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      reached_q <= powered_d && (reached_q || vcc_good_i);
    end
  end

  assign state_o   = state_q;
  assign reached_o = reached_q;
endmodule

// File: rtl/card_pwr_ctrl.sv
module card_pwr_ctrl
  import card_pwr_pkg::*;
#(
  parameter int unsigned FAULT_CYCLES = 1000,
  parameter int unsigned RAMP_CYCLES  = 2400000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_req_ni,
  input  logic vsel_5v_i,
  input  logic vcc_good_i,
  input  logic vcc_low_i,
  input  logic rst_mismatch_i,
  input  logic clk_mismatch_i,
  input  logic overtemp_i,
  input  logic dvcc_uv_i,
  input  logic card_present_i,
  input  logic chan_sel_ni,
  output logic pump_en_o,
  output logic discharge_en_o,
  output logic ready_no,
  output logic alarm_no,
  output logic vsel_5v_o,
  output logic rst_chan_en_o,
  output logic clk_chan_en_o,
  output logic data_chan_en_o
);
  pwr_state_e state;
  logic reached, take, pending, ramp_done, flt_done, powered, ready;

  card_pwr_req u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_req_ni (pwr_req_ni),
    .vsel_5v_i  (vsel_5v_i),
    .idle_i     (state == ST_IDLE),
    .take_i     (take),
    .pending_o  (pending),
    .vsel_5v_o  (vsel_5v_o)
  );

  card_pwr_timer #(.LIMIT(RAMP_CYCLES)) u_ramp_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (powered && !reached),
    .done_o (ramp_done)
  );

  card_pwr_timer #(.LIMIT(FAULT_CYCLES)) u_flt_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state == ST_FLT_WAIT),
    .done_o (flt_done)
  );

  card_pwr_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pending_i      (pending),
    .pwr_req_ni     (pwr_req_ni),
    .vcc_good_i     (vcc_good_i),
    .vcc_low_i      (vcc_low_i),
    .rst_mismatch_i (rst_mismatch_i),
    .clk_mismatch_i (clk_mismatch_i),
    .overtemp_i     (overtemp_i),
    .dvcc_uv_i      (dvcc_uv_i),
    .card_present_i (card_present_i),
    .ramp_done_i    (ramp_done),
    .flt_done_i     (flt_done),
    .state_o        (state),
    .reached_o      (reached),
    .take_o         (take)
  );

  assign powered        = (state == ST_ACTIVE) || (state == ST_FLT_WAIT);
  assign ready          = powered && reached;
  assign pump_en_o      = powered;
  assign discharge_en_o = !powered;
  assign ready_no       = !ready;
  assign alarm_no       = (state != ST_ALARM);
  assign rst_chan_en_o  = ready;
  assign clk_chan_en_o  = ready;
  assign data_chan_en_o = ready && !chan_sel_ni;
endmodule

// File: rtl/card_pwr_ctrl_chk.sv
module card_pwr_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_req_ni,
  input logic vcc_low_i,
  input logic dvcc_uv_i,
  input logic card_present_i,
  input logic chan_sel_ni,
  input logic pump_en_o,
  input logic discharge_en_o,
  input logic ready_no,
  input logic alarm_no,
  input logic vsel_5v_o,
  input logic rst_chan_en_o,
  input logic clk_chan_en_o,
  input logic data_chan_en_o
);
  // R1
  pump_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pump_en_o) |-> $past(!pwr_req_ni));
  // R2
  vsel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pump_en_o && $past(pump_en_o)) |-> $stable(vsel_5v_o));
  // R3
  ready_pump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_no || rst_chan_en_o || clk_chan_en_o) |-> (pump_en_o && !ready_no));
  // R4
  data_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_chan_en_o |-> (!chan_sel_ni && !ready_no));
  // R7
  alarm_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alarm_no |-> (ready_no && discharge_en_o && !pump_en_o && !data_chan_en_o));
  // R7
  alarm_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alarm_no && !pwr_req_ni) |=> !alarm_no);
  // R8
  discharged_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pump_en_o) |-> $past(vcc_low_i));
  // R11
  card_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pump_en_o && !card_present_i && !dvcc_uv_i && !pwr_req_ni) |=> !alarm_no);
  // R12
  uv_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pump_en_o && dvcc_uv_i) |=> (!pump_en_o && alarm_no));
endmodule

bind card_pwr_ctrl card_pwr_ctrl_chk chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pwr_req_ni     (pwr_req_ni),
  .vcc_low_i      (vcc_low_i),
  .dvcc_uv_i      (dvcc_uv_i),
  .card_present_i (card_present_i),
  .chan_sel_ni    (chan_sel_ni),
  .pump_en_o      (pump_en_o),
  .discharge_en_o (discharge_en_o),
  .ready_no       (ready_no),
  .alarm_no       (alarm_no),
  .vsel_5v_o      (vsel_5v_o),
  .rst_chan_en_o  (rst_chan_en_o),
  .clk_chan_en_o  (clk_chan_en_o),
  .data_chan_en_o (data_chan_en_o)
);

// File: tb/card_pwr_ctrl_tb.sv
module card_pwr_ctrl_tb_top;
  localparam int FLT  = 8;
  localparam int RAMP = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_req_ni = 1'b1, vsel_5v_i = 1'b0, vcc_good_i = 1'b0, vcc_low_i = 1'b1;
  logic rst_mismatch_i = 1'b0, clk_mismatch_i = 1'b0, overtemp_i = 1'b0;
  logic dvcc_uv_i = 1'b0, card_present_i = 1'b1, chan_sel_ni = 1'b0;
  logic pump_en_o, discharge_en_o, ready_no, alarm_no, vsel_5v_o;
  logic rst_chan_en_o, clk_chan_en_o, data_chan_en_o;

  always #2.5 clk_i = ~clk_i;

  card_pwr_ctrl #(.FAULT_CYCLES(FLT), .RAMP_CYCLES(RAMP)) dut_i (.*);

  typedef struct {
    int          due;
    string       req;
    logic [7:0]  exp;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  wire [7:0] obs = {pump_en_o, discharge_en_o, ready_no, alarm_no, vsel_5v_o,
                    rst_chan_en_o, clk_chan_en_o, data_chan_en_o};

  // {pump, discharge, ready_n, alarm_n, vsel, rst_en, clk_en, data_en}
  function automatic logic [7:0] idle_o(logic v);
    return {4'b0111, v, 3'b000};
  endfunction
  function automatic logic [7:0] ramp_o(logic v);
    return {4'b1011, v, 3'b000};
  endfunction
  function automatic logic [7:0] ready_o(logic v, logic d);
    return {4'b1001, v, 2'b11, d};
  endfunction
  function automatic logic [7:0] alarm_o(logic v);
    return {4'b0110, v, 3'b000};
  endfunction

  task automatic expect_in(int k, string r, logic [7:0] e);
    q.push_back('{due: cyc + k, req: r, exp: e});
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  // monitor
  always @(negedge clk_i) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        checks++;
        if (obs !== q[i].exp) begin
          errors++;
          $display("FAIL %s cycle %0d actual %b expected %b", q[i].req, cyc, obs, q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    expect_in(1, "reset", idle_o(1'b0));
    wait_cyc(2);

    // R1 R2 activation
    vsel_5v_i = 1'b1; pwr_req_ni = 1'b0;
    expect_in(1, "R2 capture", idle_o(1'b1));
    expect_in(2, "R1 pump on", ramp_o(1'b1));
    wait_cyc(2);
    vsel_5v_i = 1'b0;
    expect_in(2, "R2 select ignored", ramp_o(1'b1));
    wait_cyc(2);
    // R3
    vcc_good_i = 1'b1;
    expect_in(1, "R3 ready", ready_o(1'b1, 1'b1));
    wait_cyc(1);
    // R4
    chan_sel_ni = 1'b1;
    expect_in(1, "R4 data gated", ready_o(1'b1, 1'b0));
    wait_cyc(1);
    chan_sel_ni = 1'b0;
    expect_in(1, "R4 data reopened", ready_o(1'b1, 1'b1));
    wait_cyc(1);
    // R5 short fault
    clk_mismatch_i = 1'b1;
    wait_cyc(3);
    clk_mismatch_i = 1'b0;
    expect_in(1, "R5 short fault", ready_o(1'b1, 1'b1));
    expect_in(FLT + 2, "R5 no alarm", ready_o(1'b1, 1'b1));
    wait_cyc(FLT + 3);
    // R6 long fault
    overtemp_i = 1'b1;
    expect_in(FLT, "R6 still filtering", ready_o(1'b1, 1'b1));
    expect_in(FLT + 1, "R6 alarm", alarm_o(1'b1));
    wait_cyc(FLT + 3);
    overtemp_i = 1'b0;
    expect_in(3, "R7 alarm sticky", alarm_o(1'b1));
    wait_cyc(4);
    pwr_req_ni = 1'b1; vcc_good_i = 1'b0; vcc_low_i = 1'b0;
    expect_in(1, "R7 release to idle", idle_o(1'b1));
    wait_cyc(3);
    // R8 request while discharging
    vsel_5v_i = 1'b0; pwr_req_ni = 1'b0;
    expect_in(4, "R8 held off", idle_o(1'b0));
    wait_cyc(6);
    // R8 R9 R10
    vcc_low_i = 1'b1; rst_mismatch_i = 1'b1;
    expect_in(1, "R8 pending taken", ramp_o(1'b0));
    expect_in(12, "R9 mismatch ignored before ready", ramp_o(1'b0));
    expect_in(RAMP + FLT, "R10 filtering ramp fault", ramp_o(1'b0));
    expect_in(RAMP + FLT + 1, "R10 ramp timeout alarm", alarm_o(1'b0));
    wait_cyc(RAMP + FLT + 3);
    rst_mismatch_i = 1'b0; pwr_req_ni = 1'b1;
    expect_in(1, "R7 release", idle_o(1'b0));
    wait_cyc(2);
    // R11 card removal
    vsel_5v_i = 1'b1; pwr_req_ni = 1'b0;
    expect_in(1, "R1 pending", idle_o(1'b1));
    expect_in(2, "R1 pump on", ramp_o(1'b1));
    wait_cyc(2);
    vcc_good_i = 1'b1;
    expect_in(1, "R3 ready", ready_o(1'b1, 1'b1));
    wait_cyc(1);
    card_present_i = 1'b0;
    expect_in(1, "R11 immediate alarm", alarm_o(1'b1));
    wait_cyc(2);
    card_present_i = 1'b1; pwr_req_ni = 1'b1; vcc_good_i = 1'b0;
    expect_in(1, "R7 release", idle_o(1'b1));
    wait_cyc(2);
    // R12 controller supply loss
    vsel_5v_i = 1'b0; pwr_req_ni = 1'b0;
    expect_in(2, "R1 pump on", ramp_o(1'b0));
    wait_cyc(2);
    vcc_good_i = 1'b1;
    expect_in(1, "R3 ready", ready_o(1'b0, 1'b1));
    wait_cyc(1);
    dvcc_uv_i = 1'b1;
    expect_in(1, "R12 forced idle", idle_o(1'b0));
    expect_in(4, "R12 stays idle", idle_o(1'b0));
    wait_cyc(5);
    dvcc_uv_i = 1'b0;
    expect_in(3, "R12 no restart without new request", idle_o(1'b0));
    wait_cyc(5);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule